// File: doc/BRIEF.md
# Warp Memory Access Coalescer

The block receives one memory instruction of a warp: a byte address per lane, a mask of active lanes, an access size, and three mode bits. It breaks the instruction into the fewest aligned memory transactions that cover every active lane. Each transaction has a base address, a size code and a lane mask that names the lanes it serves. Transactions leave one per cycle over a valid/ready handshake, and a one-cycle `done` pulse closes the instruction.

A small state machine controls the block. In state `ST_IDLE` the block holds `req_ready` high. When `req_valid` is seen there, it latches the request. An all-zero mask takes the `IDLE->IDLE` transition and raises `done` in the next cycle. Any other mask takes the `IDLE->EMIT` transition. In state `ST_EMIT` a combinational picker builds the current transaction from the pending lanes. Each accepted transaction clears its lanes from the pending set. When the last lane is cleared, the block takes the `EMIT->IDLE` transition and pulses `done`. While `txn_ready` is low, the block takes the `EMIT->EMIT` transition and holds the transaction unchanged.

The cached mode emits only full 128-byte transactions. The uncached mode narrows a transaction to 64 or 32 bytes when the bytes it touches allow it. A half-warp mode coalesces the two halves of the warp separately. An atomic mode keeps lanes that target the same address in different transactions.

Top module: `warp_coalescer`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high. After reset the block is idle, with `txn_valid` and `done` low.
- R2: Lane addresses are naturally aligned to the access size. The size code on `req_size` is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes. The active lanes whose addresses fall in the same aligned 128-byte segment as the leader lane share one transaction. For example, 32 lanes reading consecutive 4-byte words of one segment give exactly one transaction.
- R3: When `req_uncached` is 0, every transaction has size code 2 (128 bytes) and a 128-byte-aligned base address.
- R4: When `req_uncached` is 1, the segment is viewed as four 32-byte chunks, where chunk k holds offsets 32k to 32k+31. The txn_size code is 0 for 32 bytes, 1 for 64 bytes and 2 for 128 bytes. If all touched bytes lie in one chunk, the transaction is 32 bytes with base at that chunk. Otherwise, if they all lie in the lower 64 bytes or all in the upper 64 bytes, the transaction is 64 bytes with base at that half. Otherwise it is 128 bytes.
- R5: When `req_half` is 1, no transaction mixes lanes 0..15 with lanes 16..31. All lanes of the lower half are emitted before any lane of the upper half.
- R6: When `req_atomic` is 1, a lane joins a transaction only if no lower-numbered lane in that transaction has the same address. As a result, equal addresses always go out in separate transactions.
- R7: The leader of each transaction is the lowest-numbered lane still pending within the current group. Transactions therefore leave in ascending order of their lowest lane.
- R8: Inactive lanes are ignored, whatever their addresses. An all-zero mask produces no transaction and a `done` pulse in the cycle after acceptance.
- R9: While `txn_valid` is high and `txn_ready` is low, `txn_addr`, `txn_size` and `txn_lanes` hold their values. After each handshake, the next transaction is offered in the following cycle.
- R10: Every active lane is served by exactly one transaction. `done` is high for one cycle, in the cycle after the final handshake, and `txn_valid` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | LANES*AW | Byte address per lane; lane i at bits [i*AW +: AW] |
| req_mask | input | LANES | Active lane mask |
| req_size | input | 2 | Access size code (R2) |
| req_uncached | input | 1 | 1: transactions may narrow to 64 or 32 bytes |
| req_half | input | 1 | 1: coalesce each half-warp separately |
| req_atomic | input | 1 | 1: separate lanes with equal addresses |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Transaction taken by the memory side |
| txn_addr | output | AW | Transaction base address |
| txn_size | output | 2 | Transaction size code (R4) |
| txn_lanes | output | LANES | Lanes served by this transaction |
| done | output | 1 | One-cycle end-of-instruction pulse |

## Verification
The bench builds the block with its default parameters: 32 lanes, 32-bit addresses, 128-byte segments and 32-byte chunks. This gives the full warp width, so the half-warp split and the 32-lane single-transaction case can be tested directly. The four chunks of a segment let the uncached narrowing produce every outcome: 32 bytes in each chunk, 64 bytes in each half, and 128 bytes. The random requests draw addresses from a few adjacent segments and a small set of repeated words. This produces straddling instructions and atomic collisions. A randomly stalling `txn_ready` exercises the hold behaviour.

// File: rtl/coal_pkg.sv
package coal_pkg;
    typedef enum logic [1:0] {
        SZ_32  = 2'd0,
        SZ_64  = 2'd1,
        SZ_128 = 2'd2
    } txn_sz_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } coal_state_e;
endpackage

// File: rtl/coal_pick.sv
module coal_pick #(
    parameter int LANES    = 32,
    parameter int AW       = 32,
    parameter int SEG_LG   = 7,
    parameter int CHUNK_LG = 5
) (
    input  logic [LANES*AW-1:0]                    addr_flat,
    input  logic [LANES-1:0]                       pend,
    input  logic                                   half,
    input  logic                                   atomic,
    input  logic [1:0]                             size_code,
    output logic [LANES-1:0]                       take,
    output logic [AW-SEG_LG-1:0]                   seg,
    output logic [(1<<(SEG_LG-CHUNK_LG))-1:0]      chunks
);
    localparam int HALF = LANES / 2;
    localparam int LW   = $clog2(LANES);

    logic [AW-1:0]     a [LANES];
    logic [LANES-1:0]  elig;
    logic [LANES-1:0]  cand;
    logic [LW-1:0]     lead;
    logic              lo_any;
    logic              dup;
    logic [SEG_LG-1:0] last_off;

    for (genvar g = 0; g < LANES; g++) begin : g_unpack
        assign a[g] = addr_flat[g*AW +: AW];
    end

    always_comb begin
        // half-warp grouping: the lower half goes first (R5)
        lo_any = half && (|pend[HALF-1:0]);
        for (int i = 0; i < LANES; i++)
            elig[i] = pend[i] && (!lo_any || i < HALF);

        // leader is the lowest eligible lane (R7)
        lead = '0;
        for (int i = LANES - 1; i >= 0; i--)
            if (elig[i]) lead = LW'(i);
        seg = a[lead][AW-1:SEG_LG];

        for (int i = 0; i < LANES; i++)
            cand[i] = elig[i] && (a[i][AW-1:SEG_LG] == seg);

        // atomic: drop a lane whose address a lower candidate already holds (R6)
        for (int j = 0; j < LANES; j++) begin
            dup = 1'b0;
            for (int i = 0; i < LANES; i++)
                if (i < j && cand[i] && a[i] == a[j]) dup = 1'b1;
            take[j] = cand[j] && !(atomic && dup);
        end

        chunks   = '0;
        last_off = '0;
        for (int j = 0; j < LANES; j++) begin
            last_off = a[j][SEG_LG-1:0] + ((SEG_LG'(1) << size_code) - SEG_LG'(1));
            if (take[j]) begin
                chunks[a[j][SEG_LG-1:CHUNK_LG]] = 1'b1;
                chunks[last_off[SEG_LG-1:CHUNK_LG]] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/coal_size.sv
module coal_size
    import coal_pkg::*;
#(
    parameter int AW       = 32,
    parameter int SEG_LG   = 7,
    parameter int CHUNK_LG = 5
) (
    input  logic [(1<<(SEG_LG-CHUNK_LG))-1:0] chunks,
    input  logic                              uncached,
    input  logic [AW-SEG_LG-1:0]              seg,
    output txn_sz_e                           size,
    output logic [AW-1:0]                     base
);
    localparam int NCH = 1 << (SEG_LG - CHUNK_LG);
    localparam int HN  = NCH / 2;

    logic [SEG_LG-1:0] off;

    always_comb begin
        size = SZ_128;
        off  = '0;
        if (uncached) begin
            if ($onehot(chunks)) begin
                size = SZ_32;
                for (int k = 0; k < NCH; k++)
                    if (chunks[k]) off = SEG_LG'(k) << CHUNK_LG;
            end else if (chunks[NCH-1:HN] == '0) begin
                size = SZ_64;
            end else if (chunks[HN-1:0] == '0) begin
                size = SZ_64;
                off  = SEG_LG'(1) << (SEG_LG - 1);
            end
        end
        base = {seg, off};
    end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import coal_pkg::*;
#(
    parameter int LANES    = 32,
    parameter int AW       = 32,
    parameter int SEG_LG   = 7,
    parameter int CHUNK_LG = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [LANES*AW-1:0] req_addr,
    input  logic [LANES-1:0]    req_mask,
    input  logic [1:0]          req_size,
    input  logic                req_uncached,
    input  logic                req_half,
    input  logic                req_atomic,
    output logic                txn_valid,
    input  logic                txn_ready,
    output logic [AW-1:0]       txn_addr,
    output logic [1:0]          txn_size,
    output logic [LANES-1:0]    txn_lanes,
    output logic                done
);
    localparam int HALF = LANES / 2;
    localparam int NCH  = 1 << (SEG_LG - CHUNK_LG);

    coal_state_e         state;
    logic [LANES*AW-1:0] addr_q;
    logic [LANES-1:0]    pend_q;
    logic [1:0]          size_q;
    logic                unc_q, half_q, atom_q, done_q;

    logic [LANES-1:0]    take;
    logic [AW-SEG_LG-1:0] seg;
    logic [NCH-1:0]      chunks;
    txn_sz_e             sz;
    logic [AW-1:0]       base;

    coal_pick #(.LANES(LANES), .AW(AW), .SEG_LG(SEG_LG), .CHUNK_LG(CHUNK_LG)) u_pick (
        .addr_flat(addr_q), .pend(pend_q), .half(half_q), .atomic(atom_q),
        .size_code(size_q), .take(take), .seg(seg), .chunks(chunks)
    );

    coal_size #(.AW(AW), .SEG_LG(SEG_LG), .CHUNK_LG(CHUNK_LG)) u_size (
        .chunks(chunks), .uncached(unc_q), .seg(seg), .size(sz), .base(base)
    );

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            pend_q <= '0;
            size_q <= '0;
            unc_q  <= 1'b0;
            half_q <= 1'b0;
            atom_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q <= req_addr;
                        pend_q <= req_mask;
                        size_q <= req_size;
                        unc_q  <= req_uncached;
                        half_q <= req_half;
                        atom_q <= req_atomic;
                        if (req_mask == '0) done_q <= 1'b1;   // IDLE->IDLE (R8)
                        else                state  <= ST_EMIT; // IDLE->EMIT
                    end
                end
                ST_EMIT: begin
                    if (txn_ready) begin
                        pend_q <= pend_q & ~take;
                        if ((pend_q & ~take) == '0) begin   // EMIT->IDLE (R10)
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // output process
    always_comb begin
        req_ready = 1'b0;
        txn_valid = 1'b0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_EMIT: txn_valid = 1'b1;
            default: ;
        endcase
        txn_addr  = base;
        txn_size  = sz;
        txn_lanes = take;
        done      = done_q;
    end

    assert_idle_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && !txn_valid));

    assert_cached_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !unc_q) |-> (txn_size == SZ_128 && txn_addr[SEG_LG-1:0] == '0));

    assert_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((txn_size == SZ_32  && txn_addr[CHUNK_LG-1:0] == '0) ||
                       (txn_size == SZ_64  && txn_addr[SEG_LG-2:0]   == '0) ||
                       (txn_size == SZ_128 && txn_addr[SEG_LG-1:0]   == '0)));

    assert_half_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && half_q) |-> !((|txn_lanes[HALF-1:0]) && (|txn_lanes[LANES-1:HALF])));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_addr) &&
                                       $stable(txn_size) && $stable(txn_lanes)));

    assert_lanes_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_lanes != '0 && (txn_lanes & ~pend_q) == '0));
endmodule

// File: tb/sim_warp_coalescer.sv
`timescale 1ns/1ps
module sim_warp_coalescer;
    localparam int LANES = 32;
    localparam int AW    = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [LANES*AW-1:0] req_addr = '0;
    logic [LANES-1:0] req_mask = '0;
    logic [1:0] req_size = 2'd2;
    logic req_uncached = 1'b0, req_half = 1'b0, req_atomic = 1'b0;
    logic txn_valid;
    logic txn_ready = 1'b0;
    logic [AW-1:0] txn_addr;
    logic [1:0] txn_size;
    logic [LANES-1:0] txn_lanes;
    logic done;

    always #5 clk = ~clk;

    warp_coalescer u0 (.*);

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    logic [31:0] la [LANES];
    logic [31:0] ex_addr [64];
    logic [1:0]  ex_sz [64];
    logic [31:0] ex_ln [64];
    int nexp;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model built from the requirements
    task automatic build_exp();
        logic [31:0] pend;
        pend = req_mask;
        nexp = 0;
        while (pend != 0) begin
            int lead;
            bit lo_any;
            logic [31:0] ln;
            logic [3:0] ch;
            logic [24:0] sg;
            logic [31:0] off;
            int sz;
            lo_any = req_half && (pend[15:0] != 0);
            lead = -1;
            for (int i = 0; i < LANES; i++)
                if (lead < 0 && pend[i] && (!lo_any || i < 16)) lead = i;
            sg = la[lead][31:7];
            ln = 0;
            ch = 0;
            for (int j = 0; j < LANES; j++) begin
                if (pend[j] && (!lo_any || j < 16) && la[j][31:7] == sg) begin
                    bit clash = 0;
                    for (int i = 0; i < j; i++)
                        if (ln[i] && la[i] == la[j]) clash = 1;
                    if (!(req_atomic && clash)) begin
                        ln[j] = 1;
                        ch[la[j][6:5]] = 1;
                        ch[((la[j] + (32'd1 << req_size) - 1) >> 5) & 3] = 1;
                    end
                end
            end
            sz = 2; off = 0;
            if (req_uncached) begin
                if ($countones(ch) == 1) begin
                    sz = 0;
                    for (int k = 0; k < 4; k++) if (ch[k]) off = k * 32;
                end else if (ch[3:2] == 0) sz = 1;
                else if (ch[1:0] == 0) begin sz = 1; off = 64; end
            end
            ex_addr[nexp] = {sg, 7'd0} + off;
            ex_sz[nexp] = 2'(sz);
            ex_ln[nexp] = ln;
            nexp++;
            pend &= ~ln;
        end
    endtask

    task automatic run_req(input string tag, input int stall_pct);
        int k;
        for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = la[i];
        build_exp();
        @(negedge clk);
        chk(req_ready == 1'b1, {"R1 ready before ", tag}, req_ready, 1);
        req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
        k = 0;
        forever begin
            @(negedge clk);
            if (k == nexp) begin
                chk(done == 1'b1 && txn_valid == 1'b0, {"R10/R8 done ", tag}, {done, txn_valid}, 2'b10);
                break;
            end
            chk(txn_valid == 1'b1 && done == 1'b0, {"R9 valid ", tag}, {done, txn_valid}, 2'b01);
            chk(txn_addr == ex_addr[k], {"R2/R4 addr ", tag}, txn_addr, ex_addr[k]);
            chk(txn_size == ex_sz[k], {"R3/R4 size ", tag}, txn_size, ex_sz[k]);
            chk(txn_lanes == ex_ln[k], {"R5/R6/R7 lanes ", tag}, txn_lanes, ex_ln[k]);
            txn_ready = ($urandom % 100) >= stall_pct;
            @(posedge clk);
            if (txn_ready) k++;
            #1 txn_ready = 1'b0;
        end
    endtask

    task automatic set_req(input logic [31:0] m, input logic [1:0] s, input bit u, input bit h, input bit at);
        req_mask = m; req_size = s; req_uncached = u; req_half = h; req_atomic = at;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !txn_valid && !done, "R1 reset state", {req_ready, txn_valid, done}, 3'b100);

        // R2: 32 consecutive words, one segment
        for (int i = 0; i < LANES; i++) la[i] = 32'h1000 + i*4;
        set_req('1, 2'd2, 0, 0, 0); run_req("R2 one segment", 0);
        chk(nexp == 1, "R2 single txn count", nexp, 1);
        set_req('1, 2'd2, 1, 0, 0); run_req("R4 uncached full", 30);

        // R4: lower half of words -> 64 B; one lane -> 32 B
        set_req(32'h0000FFFF, 2'd2, 1, 0, 0); run_req("R4 64B low", 0);
        for (int i = 0; i < LANES; i++) la[i] = 32'h2060 + (i%8)*4;
        set_req(32'h1, 2'd2, 1, 0, 0); run_req("R4 32B chunk3", 0);
        set_req(32'h1, 2'd2, 0, 0, 0); run_req("R3 cached single", 0);
        for (int i = 0; i < LANES; i++) la[i] = 32'h2040 + (i%16)*4;
        set_req(32'hFFFF, 2'd2, 1, 0, 0); run_req("R4 64B high", 0);
        // 8-byte lane ending at chunk boundary
        for (int i = 0; i < LANES; i++) la[i] = 32'h3018;
        set_req(32'h1, 2'd3, 1, 0, 0); run_req("R4 8B access", 0);

        // straddle two segments
        for (int i = 0; i < LANES; i++) la[i] = 32'h1040 + i*4;
        set_req('1, 2'd2, 0, 0, 0); run_req("R2 straddle", 50);
        chk(nexp == 2, "R2 straddle count", nexp, 2);

        // R5 half-warp
        for (int i = 0; i < LANES; i++) la[i] = 32'h4000 + i*4;
        set_req('1, 2'd2, 1, 1, 0); run_req("R5 half uncached", 0);
        chk(nexp == 2, "R5 half count", nexp, 2);

        // R6 atomic all same address
        for (int i = 0; i < LANES; i++) la[i] = 32'h5004;
        set_req('1, 2'd2, 0, 0, 1); run_req("R6 atomic same", 20);
        chk(nexp == 32, "R6 atomic count", nexp, 32);

        // R8 inactive lanes with wild addresses, and empty mask
        for (int i = 0; i < LANES; i++) la[i] = (i == 5) ? 32'h6008 : $urandom & ~32'h3;
        set_req(32'h20, 2'd2, 1, 0, 0); run_req("R8 inactive ignored", 0);
        set_req('0, 2'd2, 1, 0, 0); run_req("R8 empty mask", 0);

        // random mix
        for (int t = 0; t < 400; t++) begin
            logic [1:0] s;
            logic [31:0] bse;
            s = 2'($urandom % 4);
            bse = 32'h8000 + ($urandom % 4) * 32'h1000;
            for (int i = 0; i < LANES; i++) begin
                if ($urandom % 3 == 0) la[i] = (bse + ($urandom % 4) * 8) & ~((32'd1 << s) - 1);
                else la[i] = (bse + ($urandom % 512)) & ~((32'd1 << s) - 1);
            end
            set_req($urandom, s, 1'($urandom), 1'($urandom), ($urandom % 4) == 0);
            run_req($sformatf("R7 random %0d", t), 25);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule